// File: doc/BRIEF.md
# Split-Transaction Tag Tracker

This block sits between a requester and a system bus whose address and data tenures are split. Each new request receives a free bus transaction ID and is issued at once as an address phase carrying that ID, the request kind and the address. The block keeps a record of every transaction that is still open. Because of this record, further addresses can be issued while earlier transactions are still waiting for data.

When the data bus returns a tag, the block looks up the matching record and reports a completion. The completion carries the requester's own tag and the transaction kind, then the ID is released. Returns may arrive in any order, so a slow device never holds back a faster one. A returned ID that has no open record is flagged and otherwise dropped.

Top module: `split_txn_tracker`

## Requirements
- R1: After reset all IDs are free, `req_ready` is 1, and `abus_valid`, `cpl_valid` and `err_unknown` are 0.
- R2: An accepted request is given the lowest-numbered free ID. An ID is never issued again while its earlier transaction is still open.
- R3: A request accepted at a clock edge appears on the address bus in the following cycle as a single-cycle `abus_valid` pulse. That cycle carries the request's address, its kind and the allocated ID. The kind codes are 0 read, 1 write, 2 read-modify-write and 3 invalidate.
- R4: With all 2**ID_W IDs open, `req_ready` is 0 and a raised `req_valid` produces no address phase.
- R5: A data return whose ID is open gives, in the next cycle, a one-cycle `cpl_valid` pulse. This pulse carries that ID and the requester tag and kind stored for it. Without a data return, neither `cpl_valid` nor `err_unknown` is raised.
- R6: Open transactions complete in whatever order their data returns arrive, independent of issue order.
- R7: A data return for an ID that is not open raises `err_unknown` for one cycle and gives no completion. No open or free ID changes as a result.
- R8: In one cycle, a request can be accepted and a data return for a different ID can be completed, and both take effect.
- R9: An ID freed by its completion can be allocated to a new request from the cycle after the completion pulse. Allocation again picks the lowest free ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | New request present |
| req_ready | output | 1 | A free ID exists; the request is accepted at this edge |
| req_addr | input | ADDR_W | Request address |
| req_kind | input | 2 | Transaction kind (0 read, 1 write, 2 read-modify-write, 3 invalidate) |
| req_tag | input | TAG_W | Requester's own tag |
| abus_valid | output | 1 | Address phase pulse |
| abus_addr | output | ADDR_W | Address phase address |
| abus_kind | output | 2 | Address phase kind |
| abus_id | output | ID_W | Address phase transaction ID |
| dbus_valid | input | 1 | Data phase return present |
| dbus_id | input | ID_W | Transaction ID of the data return |
| cpl_valid | output | 1 | Completion pulse |
| cpl_id | output | ID_W | Completed transaction ID |
| cpl_tag | output | TAG_W | Requester tag of the completed transaction |
| cpl_kind | output | 2 | Kind of the completed transaction |
| err_unknown | output | 1 | Data return named an ID that was not open |

## Verification
The bench keeps the default 3-bit ID width, so all eight IDs can be opened, and it uses a 16-bit address and a 4-bit requester tag. At this size the bench can do every one of the following in a short run:
- fill the whole ID space and press against the full condition;
- return all eight IDs in a scrambled order;
- send a stray return to each of the eight IDs while none is open;
- combine an issue and a completion in one cycle.

// File: rtl/stt_pkg.sv
package stt_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_RMW   = 2'd2,
        KIND_INVAL = 2'd3
    } bus_kind_e;

    localparam int KIND_W = 2;

endpackage

// File: rtl/stt_pick_free.sv
module stt_pick_free #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  busy,
    output logic          any_free,
    output logic [IW-1:0] free_id
);
    // Scan from the top down so the last hit is the lowest free slot.
    always_comb begin
        any_free = 1'b0;
        free_id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_id  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/stt_lookup.sv
module stt_lookup #(
    parameter int N  = 8,
    parameter int IW = 3,
    parameter int TW = 4
) (
    input  logic [N-1:0]         busy,
    input  logic [N-1:0][TW-1:0] tags,
    input  logic [N-1:0][1:0]    kinds,
    input  logic [IW-1:0]        sel,
    output logic                 hit,
    output logic [TW-1:0]        tag,
    output logic [1:0]           kind
);
    assign hit  = busy[sel];
    assign tag  = tags[sel];
    assign kind = kinds[sel];
endmodule

// File: rtl/split_txn_tracker.sv
module split_txn_tracker #(
    parameter int ID_W   = 3,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              abus_valid,
    output logic [ADDR_W-1:0] abus_addr,
    output logic [1:0]        abus_kind,
    output logic [ID_W-1:0]   abus_id,
    input  logic              dbus_valid,
    input  logic [ID_W-1:0]   dbus_id,
    output logic              cpl_valid,
    output logic [ID_W-1:0]   cpl_id,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [1:0]        cpl_kind,
    output logic              err_unknown
);
    import stt_pkg::*;

    localparam int NUM_IDS = 1 << ID_W;

    typedef struct packed {
        logic [NUM_IDS-1:0]              busy;
        logic [NUM_IDS-1:0][TAG_W-1:0]   tag;
        logic [NUM_IDS-1:0][KIND_W-1:0]  kind;
        logic                            abus_valid;
        logic [ADDR_W-1:0]               abus_addr;
        bus_kind_e                       abus_kind;
        logic [ID_W-1:0]                 abus_id;
        logic                            cpl_valid;
        logic [ID_W-1:0]                 cpl_id;
        logic [TAG_W-1:0]                cpl_tag;
        bus_kind_e                       cpl_kind;
        logic                            err;
    } state_t;

    state_t d, q;

    logic              any_free;
    logic [ID_W-1:0]   free_id;
    logic              ret_hit;
    logic [TAG_W-1:0]  ret_tag;
    logic [1:0]        ret_kind;
    logic              accept;

    stt_pick_free #(.N(NUM_IDS), .IW(ID_W)) u_pick (
        .busy     (q.busy),
        .any_free (any_free),
        .free_id  (free_id)
    );

    stt_lookup #(.N(NUM_IDS), .IW(ID_W), .TW(TAG_W)) u_look (
        .busy  (q.busy),
        .tags  (q.tag),
        .kinds (q.kind),
        .sel   (dbus_id),
        .hit   (ret_hit),
        .tag   (ret_tag),
        .kind  (ret_kind)
    );

    assign accept = req_valid && any_free;

    always_comb begin
        d            = q;
        d.abus_valid = 1'b0;
        d.cpl_valid  = 1'b0;
        d.err        = 1'b0;

        // Data tenure: retire an open ID, or flag a stray tag.
        if (dbus_valid) begin
            if (ret_hit) begin
                d.busy[dbus_id] = 1'b0;
                d.cpl_valid     = 1'b1;
                d.cpl_id        = dbus_id;
                d.cpl_tag       = ret_tag;
                d.cpl_kind      = bus_kind_e'(ret_kind);
            end else begin
                d.err = 1'b1;
            end
        end

        // Address tenure: the picked ID is free, so it never meets a hit above.
        if (accept) begin
            d.busy[free_id] = 1'b1;
            d.tag[free_id]  = req_tag;
            d.kind[free_id] = req_kind;
            d.abus_valid    = 1'b1;
            d.abus_addr     = req_addr;
            d.abus_kind     = bus_kind_e'(req_kind);
            d.abus_id       = free_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = any_free;
    assign abus_valid  = q.abus_valid;
    assign abus_addr   = q.abus_addr;
    assign abus_kind   = q.abus_kind;
    assign abus_id     = q.abus_id;
    assign cpl_valid   = q.cpl_valid;
    assign cpl_id      = q.cpl_id;
    assign cpl_tag     = q.cpl_tag;
    assign cpl_kind    = q.cpl_kind;
    assign err_unknown = q.err;

endmodule

// File: rtl/stt_checker.sv
module stt_checker #(
    parameter int ID_W   = 3,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              abus_valid,
    input logic [ADDR_W-1:0] abus_addr,
    input logic [ID_W-1:0]   abus_id,
    input logic              dbus_valid,
    input logic              cpl_valid,
    input logic [ID_W-1:0]   cpl_id,
    input logic              err_unknown
);
    localparam int N = 1 << ID_W;

    // IDs seen on the address bus and not yet seen on the completion port.
    logic [N-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else begin
            shadow_q <= (shadow_q | (abus_valid ? (N'(1) << abus_id) : '0))
                        & ~(cpl_valid ? (N'(1) << cpl_id) : '0);
        end
    end

    assert_fresh_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
        abus_valid |-> !shadow_q[abus_id]);

    assert_addr_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (abus_valid && abus_addr == $past(req_addr)));

    assert_no_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !abus_valid);

    assert_cpl_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> shadow_q[cpl_id]);

    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dbus_valid |=> !(cpl_valid || err_unknown));

    assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpl_valid && err_unknown));

endmodule

bind split_txn_tracker stt_checker #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .abus_valid  (abus_valid),
    .abus_addr   (abus_addr),
    .abus_id     (abus_id),
    .dbus_valid  (dbus_valid),
    .cpl_valid   (cpl_valid),
    .cpl_id      (cpl_id),
    .err_unknown (err_unknown)
);

// File: tb/split_txn_tracker_test.sv
`timescale 1ns/1ps
module split_txn_tracker_test;
    localparam int IW = 3;
    localparam int AW = 16;
    localparam int TW = 4;
    localparam int N  = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_kind = '0;
    logic [TW-1:0] req_tag = '0;
    logic          abus_valid;
    logic [AW-1:0] abus_addr;
    logic [1:0]    abus_kind;
    logic [IW-1:0] abus_id;
    logic          dbus_valid = 1'b0;
    logic [IW-1:0] dbus_id = '0;
    logic          cpl_valid;
    logic [IW-1:0] cpl_id;
    logic [TW-1:0] cpl_tag;
    logic [1:0]    cpl_kind;
    logic          err_unknown;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit            m_busy [N];
    logic [TW-1:0] m_tag  [N];
    logic [1:0]    m_kind [N];

    always #4 clk = ~clk;

    split_txn_tracker #(.ID_W(IW), .ADDR_W(AW), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_kind(req_kind), .req_tag(req_tag),
        .abus_valid(abus_valid), .abus_addr(abus_addr), .abus_kind(abus_kind),
        .abus_id(abus_id),
        .dbus_valid(dbus_valid), .dbus_id(dbus_id),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id), .cpl_tag(cpl_tag),
        .cpl_kind(cpl_kind), .err_unknown(err_unknown)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
        return -1;
    endfunction

    // Issue one request; checks address phase one cycle later.
    task automatic issue(input logic [TW-1:0] t, input logic [1:0] k,
                         input logic [AW-1:0] a);
        int exp_id;
        exp_id = lowest_free();
        chk(req_ready == 1'b1, "R4", "ready with free id", int'(req_ready), 1);
        req_valid = 1'b1; req_tag = t; req_kind = k; req_addr = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(abus_valid == 1'b1, "R3", "abus_valid", int'(abus_valid), 1);
        chk(int'(abus_id) == exp_id, "R2", "allocated id", int'(abus_id), exp_id);
        chk(abus_addr == a, "R3", "abus_addr", int'(abus_addr), int'(a));
        chk(abus_kind == k, "R3", "abus_kind", int'(abus_kind), int'(k));
        m_busy[exp_id] = 1; m_tag[exp_id] = t; m_kind[exp_id] = k;
    endtask

    // Data return for an ID; checks completion or error one cycle later.
    task automatic give_back(input int id);
        dbus_valid = 1'b1; dbus_id = IW'(id);
        @(posedge clk); #1;
        dbus_valid = 1'b0;
        if (m_busy[id]) begin
            chk(cpl_valid == 1'b1, "R6", "cpl_valid out of order", int'(cpl_valid), 1);
            chk(int'(cpl_id) == id, "R5", "cpl_id", int'(cpl_id), id);
            chk(cpl_tag == m_tag[id], "R5", "cpl_tag", int'(cpl_tag), int'(m_tag[id]));
            chk(cpl_kind == m_kind[id], "R5", "cpl_kind", int'(cpl_kind), int'(m_kind[id]));
            chk(err_unknown == 1'b0, "R5", "no err on hit", int'(err_unknown), 0);
            m_busy[id] = 0;
        end else begin
            chk(err_unknown == 1'b1, "R7", "err on stray id", int'(err_unknown), 1);
            chk(cpl_valid == 1'b0, "R7", "no cpl on stray id", int'(cpl_valid), 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_tag[i] = '0; m_kind[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
        chk(abus_valid == 1'b0, "R1", "abus_valid", int'(abus_valid), 0);
        chk(cpl_valid == 1'b0, "R1", "cpl_valid", int'(cpl_valid), 0);
        chk(err_unknown == 1'b0, "R1", "err_unknown", int'(err_unknown), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2/R3: fill every ID, expected ids 0..N-1
        for (int i = 0; i < N; i++)
            issue(TW'(i ^ 5), 2'(i % 4), AW'(16'h1000 + i * 16'h0111));

        // R4: full, request ignored
        chk(req_ready == 1'b0, "R4", "ready when full", int'(req_ready), 0);
        req_valid = 1'b1; req_tag = 4'hF; req_addr = 16'hBEEF;
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(abus_valid == 1'b0, "R4", "no issue when full", int'(abus_valid), 0);

        // R9: free 5 then 2, reallocate in order 2 then 5
        give_back(5);
        give_back(2);
        @(posedge clk); #1;
        chk(cpl_valid == 1'b0 && err_unknown == 1'b0, "R5", "quiet idle",
            int'(cpl_valid) + int'(err_unknown), 0);
        chk(lowest_free() == 2, "R9", "model lowest", lowest_free(), 2);
        issue(4'hA, 2'd3, 16'h2222);   // R9: expected id 2
        issue(4'hB, 2'd2, 16'h5555);   // R9: expected id 5

        // R6: drain in scrambled order
        for (int i = 0; i < N; i++) give_back((i * 3 + 1) % N);

        // R7: stray returns on every id while none is open
        for (int i = 0; i < N; i++) give_back(i);
        @(posedge clk); #1;
        chk(err_unknown == 1'b0, "R7", "err lasts one cycle", int'(err_unknown), 0);
        chk(req_ready == 1'b1, "R7", "ready unchanged", int'(req_ready), 1);
        issue(4'h3, 2'd1, 16'h0303);   // R7: state untouched, expect id 0

        // R8: accept and complete in the same cycle
        req_valid = 1'b1; req_tag = 4'h9; req_kind = 2'd2; req_addr = 16'h0909;
        dbus_valid = 1'b1; dbus_id = 3'd0;
        @(posedge clk); #1;
        req_valid = 1'b0; dbus_valid = 1'b0;
        chk(abus_valid == 1'b1 && abus_id == 3'd1, "R8", "issue id 1",
            int'(abus_id), 1);
        chk(cpl_valid == 1'b1 && cpl_id == 3'd0 && cpl_tag == 4'h3, "R8",
            "complete id 0", int'(cpl_tag), 3);
        m_busy[0] = 0; m_busy[1] = 1; m_tag[1] = 4'h9; m_kind[1] = 2'd2;
        issue(4'h7, 2'd0, 16'h0707);   // R9: freed id 0 reused
        give_back(1);
        give_back(0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule